// File: doc/BRIEF.md
# Blanked Peak-Current Gate Pulse Generator

This block produces the switch-on pulse of a peak-current-mode power converter, one pulse per switching period. A timebase supplies a one-cycle strobe at the start of every period together with the length of that period in clock cycles. The strobe turns the gate on. The pulse then ends on the first of several events: the control comparator signals that the current has reached the demand of the regulation loop, the hard current-limit comparator fires, or the pulse reaches the maximum-duty point of three quarters of the period. A separate fault inhibit input pulls the gate low at once, in the same clock cycle.

Each pulse starts with a masking interval. During this interval both comparator inputs are ignored, so the switch-on current spike cannot end the pulse early. The interval is the longer of a blanking length and a minimum on-time, and the minimum on-time depends on the operating mode. In light-load (green) operation it is long. In constant-current operation it is short. The mode is sampled when the pulse starts. Each time a pulse ends, a two-bit code is stored that states why it ended. The control loop uses this code to tell regulated pulses from limited ones. The comparators themselves and slope compensation are outside the block. The block receives the smaller of the two loop demands only as the already-compared control trip flag.

Top module: `pcm_gate_gen`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the first cycle after it, the gate is low and the end-cause code is 2'b11.
- R2: A cycle-start strobe sampled while the gate is low and the inhibit is low raises the gate from the next clock cycle. A strobe sampled while the gate is already high has no effect.
- R3: During a pulse, the control trip and current-limit inputs are ignored until the gate has been high for MASK cycles. MASK is the larger of BLANK_CYC (default 30) and the mode's minimum on-time. A trip held high from the start therefore gives a pulse exactly MASK cycles long.
- R4: The minimum on-time is MINON_GREEN_CYC (default 110) when green_mode is 1 at the start strobe, and MINON_CC_CYC (default 40) when green_mode is 0.
- R5: A current-limit trip sampled after the mask ends the pulse: the gate is low from the next cycle, the code becomes 2'b01, and the gate stays low until the next start strobe, even after the trip clears.
- R6: A control trip sampled after the mask ends the pulse with code 2'b00.
- R7: A pulse lasts at most floor(3*P/4) cycles, and never less than 1 cycle. P is period_len sampled at the start strobe. A pulse ended this way gets code 2'b10. This limit wins over the minimum on-time.
- R8: When several end events occur in the same cycle, the code is chosen in this order: inhibit (2'b11), then current limit (2'b01), then control trip (2'b00), then maximum duty (2'b10).
- R9: While fault_inhibit is 1 the gate output is low in the same cycle. A pulse cut by the inhibit ends with code 2'b11. A start strobe sampled under the inhibit gives no pulse and sets the code to 2'b11.
- R10: The end-cause code keeps its value until the next pulse ends or the next inhibited start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | One-cycle strobe at the start of each switching period |
| period_len | input | CNT_W | Length of the current period in clock cycles |
| ctrl_trip | input | 1 | Control comparator: current has reached the loop demand |
| ocl_trip | input | 1 | Hard current-limit comparator |
| green_mode | input | 1 | 1 = light-load operation (long minimum on-time), 0 = constant-current operation |
| fault_inhibit | input | 1 | Protection fault; forces the gate low at once |
| gate | output | 1 | Gate drive pulse |
| end_cause | output | 2 | Why the last pulse ended: 00 control, 01 current limit, 10 max duty, 11 inhibited |

## Verification
Directed pulses hold a trip from the first cycle in each mode. This measures the mask length and separates the blanking length from the two minimum on-times. Short periods make the duty limit cut in before the mask ends, which shows that this limit wins. Coincident trips check the priority order. Single-cycle inhibits check both the same-cycle gate drop and the blocked start. Random periods, modes, trip times, inhibit pulses and extra strobes are then compared cycle by cycle against a bench model of the requirements. This shows whether each end event is handled correctly at every point of a pulse.

// File: rtl/pcm_pkg.sv
// Shared types and helpers for the gate pulse generator.
// Assumes: all counts are in clock cycles.
package pcm_pkg;

    // Reason the most recent pulse ended.
    typedef enum logic [1:0] {
        END_CTRL = 2'b00,
        END_OCL  = 2'b01,
        END_MAXD = 2'b10,
        END_INH  = 2'b11
    } end_cause_e;

    // Larger of two elaboration-time counts.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcm_window.sv
// Captures the per-pulse limits when a pulse starts: the maximum-duty
// length from the period, and the comparator mask length from the mode.
// Assumes: load is high only in the cycle the pulse is started.
module pcm_window #(
    parameter int unsigned CNT_W           = 16,
    parameter int unsigned BLANK_CYC       = 30,
    parameter int unsigned MINON_GREEN_CYC = 110,
    parameter int unsigned MINON_CC_CYC    = 40,
    parameter int unsigned DUTY_NUM        = 3,
    parameter int unsigned DUTY_SHIFT      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] period_len,
    input  logic             green_mode,
    output logic [CNT_W-1:0] lim_q,
    output logic [CNT_W-1:0] mask_q
);
    import pcm_pkg::*;

    localparam int unsigned MASK_GREEN = max_u(BLANK_CYC, MINON_GREEN_CYC);
    localparam int unsigned MASK_CC    = max_u(BLANK_CYC, MINON_CC_CYC);
    localparam int unsigned PROD_W     = CNT_W + 8;

    logic [PROD_W-1:0] prod;

    // Duty product: shift-add for the 3/4 default, general multiply otherwise.
    generate
        if (DUTY_NUM == 3) begin : g_shift_add
            always_comb prod = ({8'd0, period_len} << 1) + {8'd0, period_len};
        end else begin : g_mult
            always_comb prod = {8'd0, period_len} * PROD_W'(DUTY_NUM);
        end
    endgenerate

    // Latch both limits at pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= '0;
            mask_q <= CNT_W'(MASK_CC);
        end else if (load) begin
            lim_q  <= CNT_W'(prod >> DUTY_SHIFT);
            mask_q <= green_mode ? CNT_W'(MASK_GREEN) : CNT_W'(MASK_CC);
        end
    end

endmodule

// File: rtl/pcm_on_timer.sv
// Counts the cycles the gate has been high and flags when the mask
// and the duty limit are reached by the cycle ending at the next edge.
// Assumes: clear is high in the start cycle; run is high while the gate is on.
module pcm_on_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] mask_q,
    input  logic [CNT_W-1:0] lim_q,
    output logic             mask_met,
    output logic             lim_met
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nxt;

    // Number of high cycles once the current cycle completes.
    always_comb cnt_nxt = {1'b0, cnt_q} + 1'b1;

    // Saturating on-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && !cnt_nxt[CNT_W]) begin
            cnt_q <= cnt_nxt[CNT_W-1:0];
        end
    end

    // Threshold compares against the latched limits.
    always_comb begin
        mask_met = cnt_nxt >= {1'b0, mask_q};
        lim_met  = cnt_nxt >= {1'b0, lim_q};
    end

endmodule

// File: rtl/pcm_gate_gen.sv
// Peak-current gate pulse generator: turns the gate on at each period
// strobe and off at the first qualified trip, current limit, duty
// limit or fault inhibit, and stores the cause of each turn-off.
// Assumes: comparator inputs are already synchronous to clk.
module pcm_gate_gen #(
    parameter int unsigned CNT_W           = 16,
    parameter int unsigned BLANK_CYC       = 30,
    parameter int unsigned MINON_GREEN_CYC = 110,
    parameter int unsigned MINON_CC_CYC    = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [CNT_W-1:0] period_len,
    input  logic             ctrl_trip,
    input  logic             ocl_trip,
    input  logic             green_mode,
    input  logic             fault_inhibit,
    output logic             gate,
    output logic [1:0]       end_cause
);
    import pcm_pkg::*;

    logic             gate_q;
    end_cause_e       cause_q;
    logic             start_ok;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] mask_q;
    logic             mask_met;
    logic             lim_met;

    // A new pulse starts only from the low state, with no inhibit.
    always_comb start_ok = cyc_start && !gate_q && !fault_inhibit;

    pcm_window #(
        .CNT_W          (CNT_W),
        .BLANK_CYC      (BLANK_CYC),
        .MINON_GREEN_CYC(MINON_GREEN_CYC),
        .MINON_CC_CYC   (MINON_CC_CYC),
        .DUTY_NUM       (3),
        .DUTY_SHIFT     (2)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .period_len(period_len),
        .green_mode(green_mode),
        .lim_q     (lim_q),
        .mask_q    (mask_q)
    );

    pcm_on_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_ok),
        .run     (gate_q),
        .mask_q  (mask_q),
        .lim_q   (lim_q),
        .mask_met(mask_met),
        .lim_met (lim_met)
    );

    // Gate state and end cause, with priority inhibit > limit > control > duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            cause_q <= END_INH;
        end else if (!gate_q) begin
            if (start_ok) begin
                gate_q <= 1'b1;
            end else if (cyc_start && fault_inhibit) begin
                cause_q <= END_INH;
            end
        end else if (fault_inhibit) begin
            gate_q  <= 1'b0;
            cause_q <= END_INH;
        end else if (ocl_trip && mask_met) begin
            gate_q  <= 1'b0;
            cause_q <= END_OCL;
        end else if (ctrl_trip && mask_met) begin
            gate_q  <= 1'b0;
            cause_q <= END_CTRL;
        end else if (lim_met) begin
            gate_q  <= 1'b0;
            cause_q <= END_MAXD;
        end
    end

    // Inhibit drops the gate in the same cycle.
    always_comb begin
        gate      = gate_q && !fault_inhibit;
        end_cause = cause_q;
    end

endmodule

// File: rtl/pcm_gate_gen_chk.sv
// Checker for the gate pulse generator: measures each pulse length on
// its own and relates it to the stored end cause and to the inputs.
// Assumes: bound into pcm_gate_gen with access to its gate register.
module pcm_gate_gen_chk #(
    parameter int unsigned CNT_W           = 16,
    parameter int unsigned BLANK_CYC       = 30,
    parameter int unsigned MINON_GREEN_CYC = 110,
    parameter int unsigned MINON_CC_CYC    = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_start,
    input logic       fault_inhibit,
    input logic       gate,
    input logic [1:0] end_cause,
    input logic       gate_q
);
    localparam int unsigned MINON_LO = (MINON_CC_CYC < MINON_GREEN_CYC) ? MINON_CC_CYC : MINON_GREEN_CYC;
    localparam int unsigned LOW_MASK = (BLANK_CYC > MINON_LO) ? BLANK_CYC : MINON_LO;

    logic [CNT_W:0] run_len;

    // Length of the current or just-finished pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else        run_len <= gate_q ? run_len + 1'b1 : '0;
    end

    // R2: the gate only rises after a start strobe.
    p_rise_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(cyc_start));

    // R9: inhibit keeps the gate low in the same cycle.
    p_inhibit_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_inhibit |-> !gate);

    // R9: a pulse cut by inhibit ends with the inhibit code.
    p_inhibit_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && fault_inhibit) |=> (!gate_q && end_cause == 2'b11));

    // R3: a comparator-ended pulse lasted at least the shortest mask.
    p_mask_respected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && $past(gate_q) && !end_cause[1]) |-> (run_len >= (CNT_W+1)'(LOW_MASK)));

    // R10: the code holds while no pulse is running and no start arrives.
    p_cause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(gate_q) && !$past(cyc_start)) |-> $stable(end_cause));

endmodule

bind pcm_gate_gen pcm_gate_gen_chk #(
    .CNT_W          (CNT_W),
    .BLANK_CYC      (BLANK_CYC),
    .MINON_GREEN_CYC(MINON_GREEN_CYC),
    .MINON_CC_CYC   (MINON_CC_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start    (cyc_start),
    .fault_inhibit(fault_inhibit),
    .gate         (gate),
    .end_cause    (end_cause),
    .gate_q       (gate_q)
);

// File: tb/pcm_gate_gen_bench.sv
// Bench for pcm_gate_gen: directed corner pulses plus seeded random
// periods, compared each cycle against a model built from the requirements.
module pcm_gate_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int BLANK      = 30;
    localparam int MG         = 110;
    localparam int MC         = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_start = 1'b0;
    logic [CNT_W-1:0] period_len = '0;
    logic             ctrl_trip = 1'b0;
    logic             ocl_trip = 1'b0;
    logic             green_mode = 1'b0;
    logic             fault_inhibit = 1'b0;
    logic             gate;
    logic [1:0]       end_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state.
    bit m_gate = 1'b0;
    int m_cnt = 0;
    int m_lim = 0;
    int m_mask = MC;
    logic [1:0] m_cause = 2'b11;
    int hi_len = 0;

    pcm_gate_gen #(
        .CNT_W(CNT_W), .BLANK_CYC(BLANK), .MINON_GREEN_CYC(MG), .MINON_CC_CYC(MC)
    ) u_pcm_gate_gen (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .period_len(period_len),
        .ctrl_trip(ctrl_trip), .ocl_trip(ocl_trip), .green_mode(green_mode),
        .fault_inhibit(fault_inhibit), .gate(gate), .end_cause(end_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_mask(input bit gr);
        int mo = gr ? MG : MC;
        return (BLANK > mo) ? BLANK : mo;
    endfunction

    function automatic int exp_lim(input int per);
        return (per * 3) / 4;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at a clock edge from the sampled inputs.
    task automatic model_step(input bit s, input int per, input bit ct, input bit oc,
                              input bit gr, input bit inh);
        if (!m_gate) begin
            if (s) begin
                if (inh) m_cause = 2'b11;
                else begin
                    m_gate = 1'b1; m_cnt = 0;
                    m_lim = exp_lim(per); m_mask = exp_mask(gr);
                end
            end
        end else begin
            int n = m_cnt + 1;
            if (inh)                       begin m_gate = 1'b0; m_cause = 2'b11; end
            else if (oc && n >= m_mask)    begin m_gate = 1'b0; m_cause = 2'b01; end
            else if (ct && n >= m_mask)    begin m_gate = 1'b0; m_cause = 2'b00; end
            else if (n >= m_lim)           begin m_gate = 1'b0; m_cause = 2'b10; end
            else m_cnt = n;
        end
    endtask

    // One clock cycle: drive at the falling edge, compare after the rising edge.
    task automatic cyc(input string tag, input bit s, input int per, input bit ct,
                       input bit oc, input bit gr, input bit inh);
        @(negedge clk);
        cyc_start = s; period_len = CNT_W'(per); ctrl_trip = ct;
        ocl_trip = oc; green_mode = gr; fault_inhibit = inh;
        #1;
        if (inh) check({tag, " R9 same-cycle gate"}, gate, 0);
        @(posedge clk);
        model_step(s, per, ct, oc, gr, inh);
        #1;
        check({tag, " gate"}, gate, (m_gate && !inh) ? 1 : 0);
        check({tag, " cause"}, end_cause, m_cause);
        if (gate) hi_len++;
    endtask

    // One whole period. Event times at or beyond per never happen.
    task automatic period(input string tag, input int per, input bit gr, input int t_ct,
                          input int t_oc, input int t_inh, input int t_s2);
        hi_len = 0;
        for (int k = 0; k < per; k++) begin
            cyc(tag, (k == 0) || (k == t_s2), per, k >= t_ct, (k >= t_oc) && (k < t_oc + 3),
                gr, k == t_inh);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed_v;
        seed_v = $urandom(1234);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset gate", gate, 0);
        check("R1 reset cause", end_cause, 2'b11);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset gate", gate, 0);
        check("R1 after reset cause", end_cause, 2'b11);

        // R3 R4 R6: trip held from start gives exactly the mask length.
        period("R6 cc", 200, 1'b0, 0, 999, 999, 999);
        check("R4 cc min on length", hi_len, exp_mask(1'b0));
        check("R6 cause ctrl", end_cause, 2'b00);
        period("R3 green", 300, 1'b1, 0, 999, 999, 999);
        check("R3 green mask length", hi_len, exp_mask(1'b1));
        // R5: current limit, gate stays low after trip clears.
        period("R5 ocl", 200, 1'b0, 999, 70, 999, 999);
        check("R5 cause ocl", end_cause, 2'b01);
        check("R5 ocl length", hi_len, 70);
        // R7: duty limit, also winning over the green minimum on-time.
        period("R7 duty", 100, 1'b0, 999, 999, 999, 999);
        check("R7 duty length", hi_len, 75);
        check("R7 cause duty", end_cause, 2'b10);
        period("R7 duty over min on", 40, 1'b1, 0, 999, 999, 999);
        check("R7 duty beats min on", hi_len, 30);
        // R8: control and current limit together: current limit wins.
        period("R8 both", 200, 1'b0, 50, 50, 999, 999);
        check("R8 cause priority", end_cause, 2'b01);
        // R9: inhibit mid pulse, then inhibited start.
        period("R9 mid", 200, 1'b0, 999, 999, 20, 999);
        check("R9 cause inhibit", end_cause, 2'b11);
        period("R6 recover", 200, 1'b0, 60, 999, 999, 999);
        period("R9 start", 100, 1'b0, 999, 999, 0, 999);
        check("R9 inhibited start length", hi_len, 0);
        check("R9 inhibited start cause", end_cause, 2'b11);
        // R2: extra strobe mid-pulse has no effect.
        period("R2 extra strobe", 200, 1'b0, 90, 999, 999, 40);
        check("R2 extra strobe length", hi_len, 90);
        check("R10 cause held", end_cause, 2'b00);

        // Random periods.
        for (int i = 0; i < 400; i++) begin
            int per, tct, toc, tinh, ts2;
            per  = 20 + int'($urandom % 300);
            tct  = int'($urandom % (per + 20));
            toc  = ($urandom % 5 == 0) ? int'($urandom % per) : 999;
            tinh = ($urandom % 8 == 0) ? int'($urandom % per) : 999;
            ts2  = ($urandom % 10 == 0) ? 1 + int'($urandom % (per - 1)) : 999;
            period("R8 random", per, 1'($urandom % 2), tct, toc, tinh, ts2);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule